// File: doc/BRIEF.md
# Fast Call and Return Unit

This block carries out a lightweight subroutine linkage for a processor core. A call saves only the current link (return-address) register on a stack that grows toward lower addresses, loads the link register with the address of the instruction after the call, and redirects the program counter. A return does the reverse. It jumps to the link value with its lowest bit forced to zero, then reloads the link register from the top of the stack and releases that stack slot. No other registers are saved or restored.

A call can name its target in three ways. A signed 24-bit displacement can be taken relative to the current PC. The same 24-bit field can instead be spread into an absolute address, with its top four bits going to the top of the address and the other twenty bits sitting one position above bit 0. The third way is an address taken from a register. Each request makes one word access through a simple request/acknowledge memory port. The stack pointer, link register and PC outputs change together with a one-cycle completion pulse. While a request is in progress, further requests are ignored.

Top module: `fcall_unit`

## Requirements
- R1: When reset is released, `sp_o` equals `SP_RESET`, `ra_o` equals `RA_RESET` and `pc_o` equals `PC_RESET`. `busy` and `done` are low, and neither memory enable is asserted.
- R2: A call request (`req_kind` 0, 1 or 2) makes exactly one memory write and no read. The write goes to address `sp_o - 4` and its data is the value `ra_o` had before the call.
- R3: After a call completes, `sp_o` is 4 less than before, and `ra_o` equals the `req_next_pc` supplied with the request.
- R4: For `req_kind` 0 (relative call), the new `pc_o` is `req_pc` plus twice the sign-extended 24-bit `req_disp`, computed modulo 2^32.
- R5: For `req_kind` 1 (absolute call), `req_disp` bits 23:20 land in `pc_o` bits 31:28, `req_disp` bits 19:0 land in `pc_o` bits 20:1, and every other bit of `pc_o` is zero.
- R6: For `req_kind` 2 (indirect call), the new `pc_o` is `req_addr` with bit 0 cleared.
- R7: A return request (`req_kind` 3) makes exactly one memory read, at address `sp_o`, and no write. Afterwards `pc_o` is the old `ra_o` with bit 0 cleared, `ra_o` is the word that was read, and `sp_o` is 4 greater than before.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the clock edge on which `mem_ack` was sampled high for the access. `sp_o`, `ra_o` and `pc_o` change only in a cycle where `done` is high.
- R9: `req_valid` has no effect while `busy` is high. When `busy` is low, neither memory enable is asserted.
- R10: An access waits for `mem_ack` for as many cycles as memory takes. Until then its enable stays asserted and its address stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally for release |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_kind | input | 2 | 0 relative call, 1 absolute call, 2 indirect call, 3 return |
| req_pc | input | AW | PC of the requesting instruction |
| req_next_pc | input | AW | Address of the instruction following the call |
| req_disp | input | DISP_W | Displacement field for relative and absolute calls |
| req_addr | input | AW | Register operand for indirect calls |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_wr_en | output | 1 | Stack push write request |
| mem_wr_addr | output | AW | Push address |
| mem_wr_data | output | AW | Push data (previous link value) |
| mem_rd_en | output | 1 | Stack pop read request |
| mem_rd_addr | output | AW | Pop address |
| mem_rd_data | input | AW | Pop data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge for the pending access |
| sp_o | output | AW | Stack pointer |
| ra_o | output | AW | Link (return-address) register |
| pc_o | output | AW | Program counter after the last completed request |

## Verification
Some properties are checked by assertions on every cycle. The two memory enables are never asserted together, and neither is asserted while the unit is idle. A pending access keeps its enable and address until it is acknowledged. `done` never lasts more than one cycle. Any change to stack pointer, link or PC coincides with `done`. On every pop, the stack pointer rises by four, the link takes the read word, and the PC comes out even. Other behaviour is shown only by the bench's sweeps. These cover target arithmetic across displacement extremes and sign boundaries, the push data that lands in memory, the link value loaded by each call, nested call/return sequences that unwind correctly, completion timing under varied acknowledge latency, and requests raised while busy having no effect.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

  typedef enum logic [1:0] {
    KIND_REL = 2'd0,
    KIND_ABS = 2'd1,
    KIND_IND = 2'd2,
    KIND_RET = 2'd3
  } fcu_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2,
    ST_DONE = 2'd3
  } fcu_state_e;

  localparam int unsigned SEG_W = 4;

endpackage

// File: rtl/fcu_target.sv
module fcu_target
  import fcu_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DISP_W = 24
) (
  input  fcu_kind_e         kind,
  input  logic [AW-1:0]     cur_pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     ind_addr,
  input  logic [AW-1:0]     link_val,
  output logic [AW-1:0]     target
);

  localparam int unsigned OFS_W = DISP_W - SEG_W;
  localparam int unsigned EXT_W = AW - DISP_W;
  localparam logic [AW-1:0] ODD_MASK = {{(AW-1){1'b1}}, 1'b0};

  logic [AW-1:0] disp_sx;
  logic [AW-1:0] rel_tgt;
  logic [AW-1:0] abs_tgt;
  logic [AW-1:0] ind_tgt;
  logic [AW-1:0] ret_tgt;

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_nosext
      assign disp_sx = disp[AW-1:0];
    end
  endgenerate

  assign rel_tgt = cur_pc + (disp_sx << 1);

  always_comb begin
    abs_tgt                  = '0;
    abs_tgt[AW-1 -: SEG_W]   = disp[DISP_W-1 -: SEG_W];
    abs_tgt[OFS_W:1]         = disp[OFS_W-1:0];
  end

  assign ind_tgt = ind_addr & ODD_MASK;
  assign ret_tgt = link_val & ODD_MASK;

  always_comb begin
    unique case (kind)
      KIND_REL: target = rel_tgt;
      KIND_ABS: target = abs_tgt;
      KIND_IND: target = ind_tgt;
      default:  target = ret_tgt;
    endcase
  end

endmodule

// File: rtl/fcu_seq.sv
module fcu_seq
  import fcu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_ret,
  input  logic mem_ack,
  output logic busy,
  output logic wr_en,
  output logic rd_en,
  output logic commit,
  output logic done
);

  fcu_state_e state_q;
  fcu_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = start_ret ? ST_POP : ST_PUSH;
      ST_PUSH: if (mem_ack) state_d = ST_DONE;
      ST_POP:  if (mem_ack) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy   = (state_q != ST_IDLE);
  assign wr_en  = (state_q == ST_PUSH);
  assign rd_en  = (state_q == ST_POP);
  assign commit = (wr_en || rd_en) && mem_ack;
  assign done   = (state_q == ST_DONE);

endmodule

// File: rtl/fcu_arch_regs.sv
module fcu_arch_regs #(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   STEP     = 4,
  parameter logic [AW-1:0] SP_RESET = '0,
  parameter logic [AW-1:0] RA_RESET = '0,
  parameter logic [AW-1:0] PC_RESET = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          is_ret,
  input  logic [AW-1:0] tgt_pc,
  input  logic [AW-1:0] link_addr,
  input  logic [AW-1:0] pop_word,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] ra,
  output logic [AW-1:0] pc
);

  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  logic [AW-1:0] sp_d, ra_d, pc_d;

  always_comb begin
    sp_d = sp;
    ra_d = ra;
    pc_d = pc;
    if (commit) begin
      pc_d = tgt_pc;
      if (is_ret) begin
        ra_d = pop_word;
        sp_d = sp + STEP_A;
      end else begin
        ra_d = link_addr;
        sp_d = sp - STEP_A;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= SP_RESET;
      ra <= RA_RESET;
      pc <= PC_RESET;
    end else if (commit) begin
      sp <= sp_d;
      ra <= ra_d;
      pc <= pc_d;
    end
  end

endmodule

// File: rtl/fcall_unit.sv
module fcall_unit
  import fcu_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DISP_W   = 24,
  parameter int unsigned   STEP     = 4,
  parameter logic [AW-1:0] SP_RESET = 32'h0000_0400,
  parameter logic [AW-1:0] RA_RESET = 32'h0000_0000,
  parameter logic [AW-1:0] PC_RESET = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [AW-1:0]     req_pc,
  input  logic [AW-1:0]     req_next_pc,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [AW-1:0]     req_addr,
  output logic              busy,
  output logic              done,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [AW-1:0]     mem_wr_data,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [AW-1:0]     mem_rd_data,
  input  logic              mem_ack,
  output logic [AW-1:0]     sp_o,
  output logic [AW-1:0]     ra_o,
  output logic [AW-1:0]     pc_o
);

  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  fcu_kind_e     kind_in;
  logic          accept;
  logic [AW-1:0] tgt_in;
  logic          commit;

  logic          ret_q, ret_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [AW-1:0] link_q, link_d;

  assign kind_in = fcu_kind_e'(req_kind);
  assign accept  = req_valid && !busy;

  fcu_target #(.AW(AW), .DISP_W(DISP_W)) u_target (
    .kind     (kind_in),
    .cur_pc   (req_pc),
    .disp     (req_disp),
    .ind_addr (req_addr),
    .link_val (ra_o),
    .target   (tgt_in)
  );

  // request latch: next-state and register kept apart
  always_comb begin
    ret_d  = ret_q;
    tgt_d  = tgt_q;
    link_d = link_q;
    if (accept) begin
      ret_d  = (kind_in == KIND_RET);
      tgt_d  = tgt_in;
      link_d = req_next_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ret_q  <= 1'b0;
      tgt_q  <= '0;
      link_q <= '0;
    end else if (accept) begin
      ret_q  <= ret_d;
      tgt_q  <= tgt_d;
      link_q <= link_d;
    end
  end

  fcu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (req_valid),
    .start_ret (kind_in == KIND_RET),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .wr_en     (mem_wr_en),
    .rd_en     (mem_rd_en),
    .commit    (commit),
    .done      (done)
  );

  fcu_arch_regs #(
    .AW(AW), .STEP(STEP),
    .SP_RESET(SP_RESET), .RA_RESET(RA_RESET), .PC_RESET(PC_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .commit    (commit),
    .is_ret    (ret_q),
    .tgt_pc    (tgt_q),
    .link_addr (link_q),
    .pop_word  (mem_rd_data),
    .sp        (sp_o),
    .ra        (ra_o),
    .pc        (pc_o)
  );

  assign mem_wr_addr = sp_o - STEP_A;
  assign mem_wr_data = ra_o;
  assign mem_rd_addr = sp_o;

endmodule

// File: rtl/fcu_checker.sv
module fcu_checker #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_wr_addr,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic [AW-1:0] mem_rd_data,
  input logic          mem_ack,
  input logic [AW-1:0] sp_o,
  input logic [AW-1:0] ra_o,
  input logic [AW-1:0] pc_o
);

  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  AST_PORTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_en)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr_en && !mem_rd_en)); // R9

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_ack) |=> (mem_wr_en && $stable(mem_wr_addr))); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_ack) |=> (mem_rd_en && $stable(mem_rd_addr))); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_SP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_o != $past(sp_o)) |-> done); // R8

  AST_RA_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_o != $past(ra_o)) |-> done); // R8

  AST_PC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o != $past(pc_o)) |-> done); // R8

  AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_wr_en)) |-> (sp_o == $past(sp_o) - STEP_A)); // R3

  AST_POP_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_rd_en)) |-> (sp_o == $past(sp_o) + STEP_A)); // R7

  AST_POP_RA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_rd_en)) |-> (ra_o == $past(mem_rd_data))); // R7

  AST_POP_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_rd_en)) |-> (pc_o[0] == 1'b0)); // R7

endmodule

bind fcall_unit fcu_checker #(.AW(AW), .STEP(STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .busy        (busy),
  .done        (done),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_data (mem_rd_data),
  .mem_ack     (mem_ack),
  .sp_o        (sp_o),
  .ra_o        (ra_o),
  .pc_o        (pc_o)
);

// File: tb/fcall_unit_tb_top.sv
module fcall_unit_tb_top;

  localparam logic [31:0] SP_R = 32'h0000_0400;
  localparam logic [31:0] RA_R = 32'h0000_0000;
  localparam logic [31:0] PC_R = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [31:0] req_pc, req_next_pc, req_addr;
  logic [23:0] req_disp;
  logic        busy, done, mem_wr_en, mem_rd_en, mem_ack;
  logic [31:0] mem_wr_addr, mem_wr_data, mem_rd_addr, mem_rd_data;
  logic [31:0] sp_o, ra_o, pc_o;

  always #10 clk = ~clk;

  fcall_unit #(.SP_RESET(SP_R), .RA_RESET(RA_R), .PC_RESET(PC_R)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_pc(req_pc), .req_next_pc(req_next_pc), .req_disp(req_disp),
    .req_addr(req_addr), .busy(busy), .done(done),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_ack(mem_ack), .sp_o(sp_o), .ra_o(ra_o), .pc_o(pc_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // memory model with programmable acknowledge latency
  logic [31:0] mem [0:255];
  logic [31:0] exp_mem [0:255];
  int lat = 0;
  int lat_cnt;

  function automatic int unsigned widx(logic [31:0] a);
    return (a >> 2) & 32'd255;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack     <= 1'b0;
      lat_cnt     <= 0;
      mem_rd_data <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_wr_en || mem_rd_en) begin
      if (lat_cnt >= lat) begin
        mem_ack <= 1'b1;
        if (mem_wr_en) mem[widx(mem_wr_addr)] <= mem_wr_data;
        else           mem_rd_data <= mem[widx(mem_rd_addr)];
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  logic [31:0] exp_sp, exp_ra, exp_pc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] kind, input logic [23:0] disp,
                        input logic [31:0] addr, input int lat_v, input bit inject);
    logic [31:0] tgt, sx, push_addr;
    bit is_call;
    int steps;
    @(negedge clk);
    lat         = lat_v;
    req_valid   = 1'b1;
    req_kind    = kind;
    req_pc      = exp_pc;
    req_next_pc = exp_pc + 32'd4;
    req_disp    = disp;
    req_addr    = addr;
    is_call     = (kind != 2'd3);
    push_addr   = exp_sp - 32'd4;
    sx          = {{8{disp[23]}}, disp};
    case (kind)
      2'd0: tgt = exp_pc + sx + sx;                                   // R4
      2'd1: tgt = {disp[23:20], 7'd0, disp[19:0], 1'b0};              // R5
      2'd2: tgt = {addr[31:1], 1'b0};                                 // R6
      default: tgt = {exp_ra[31:1], 1'b0};                            // R7
    endcase
    if (is_call) begin
      exp_mem[widx(push_addr)] = exp_ra;
      exp_sp = push_addr;
      exp_ra = exp_pc + 32'd4;
    end else begin
      exp_ra = exp_mem[widx(exp_sp)];
      exp_sp = exp_sp + 32'd4;
    end
    exp_pc = tgt;
    @(negedge clk);
    if (inject) begin
      req_kind = ~kind;
      req_disp = ~disp;
      req_addr = ~addr;
    end else begin
      req_valid = 1'b0;
    end
    steps = 1;
    while (!done && steps < 60) begin
      @(negedge clk);
      req_valid = 1'b0;
      steps++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: done never seen, actual 0 expected 1");
    end
    chk("R8 completion latency", steps, lat_v + 3);
    chk(is_call ? "R4/R5/R6 call target" : "R7 return pc", pc_o, exp_pc);
    chk(is_call ? "R3 link value" : "R7 link reload", ra_o, exp_ra);
    chk(is_call ? "R3 sp decrement" : "R7 sp increment", sp_o, exp_sp);
    if (is_call) chk("R2 pushed word", mem[widx(push_addr)], exp_mem[widx(push_addr)]);
    @(negedge clk);
    chk("R8 done single cycle", {31'd0, done}, 32'd0);
    chk("R9 idle after op", {30'd0, busy, mem_wr_en | mem_rd_en}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [23:0] rel_set [0:5];
  logic [23:0] abs_set [0:5];
  logic [31:0] ind_set [0:3];

  initial begin
    rel_set = '{24'h000000, 24'h000001, 24'hFFFFFF, 24'h7FFFFF, 24'h800000, 24'h123456};
    abs_set = '{24'h000000, 24'hFFFFFF, 24'h800001, 24'h0FFFFF, 24'h100000, 24'hA5A5A5};
    ind_set = '{32'h0000_2001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 32'h5A00_0001 ^ (i * 32'h0001_0203);
      exp_mem[i] = 32'h5A00_0001 ^ (i * 32'h0001_0203);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0;
    req_pc = '0; req_next_pc = '0; req_disp = '0; req_addr = '0;
    exp_sp = SP_R; exp_ra = RA_R; exp_pc = PC_R;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sp reset", sp_o, SP_R);
    chk("R1 ra reset", ra_o, RA_R);
    chk("R1 pc reset", pc_o, PC_R);
    chk("R1 quiet reset", {29'd0, busy, done, mem_wr_en | mem_rd_en}, 32'd0);

    // R4 relative sweep, each call unwound by a return
    for (int i = 0; i < 6; i++) begin
      run_op(2'd0, rel_set[i], 32'd0, i % 3, 1'b0);
      run_op(2'd3, 24'd0, 32'd0, (i + 1) % 3, 1'b0);
    end
    // R5 absolute sweep
    for (int i = 0; i < 6; i++) begin
      run_op(2'd1, abs_set[i], 32'd0, (i + 2) % 3, 1'b0);
      run_op(2'd3, 24'd0, 32'd0, i % 3, 1'b0);
    end
    // R6 indirect sweep
    for (int i = 0; i < 4; i++) begin
      run_op(2'd2, 24'd0, ind_set[i], i % 4, 1'b0);
      run_op(2'd3, 24'd0, 32'd0, 0, 1'b0);
    end
    // nested calls then full unwind, R9 injections while busy
    for (int i = 0; i < 9; i++)
      run_op(2'(i % 3), rel_set[i % 6] ^ abs_set[(i + 1) % 6], ind_set[i % 4], i % 4, i[0]);
    for (int i = 0; i < 9; i++)
      run_op(2'd3, 24'h00FFFF, 32'hFFFF_FFFF, (i * 3) % 4, i[1]);
    // R7 returns popping words present since reset
    run_op(2'd3, 24'd0, 32'd0, 1, 1'b0);
    run_op(2'd3, 24'd0, 32'd0, 2, 1'b1);
    // R10 long wait states
    run_op(2'd1, 24'hF00001, 32'd0, 7, 1'b0);
    run_op(2'd3, 24'd0, 32'd0, 9, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule